// File: doc/BRIEF.md
# Gradual clock source switch sequencer

This controller moves a CPU core clock between its main PLL and an alternate fixed-rate PLL. Where the switch would otherwise cause a sharp jump in core frequency, it steps an integer post-divider around the change. A request gives the direction (to the alternate source or back to the main one) and three integer frequency codes: the old rate, the new target rate and the alternate rate.

When a request is accepted, the block computes a temporary divider. This is the alternate rate divided by the larger of the old and new rates, rounded up. The block then drives a registered divider value and a registered source-select bit through a fixed ordering of steps. The clock mux, the divider datapath and PLL relocking lie outside the block; its two outputs stand in for their control inputs.

For a divide-by-1 switch across a wide frequency gap, the block does not flip the mux at once. It runs a five-step ramp (divide by 2, divide by 3, switch, divide by 2, divide by 1) and waits a settle time of 10 microseconds between steps. That wait is counted in controller clock cycles.

Top module: `clk_src_ramp_seq`

## Requirements
- R1: After reset, `div_out` is 1, `sel_alt` is 0 (0 = main source, 1 = alternate source), and `busy`, `done` and `err` are all 0.
- R2: The temporary divider D is ceil(`alt_rate` / max(`old_rate`, `new_rate`)). A result of 0 is treated as 1. D is the value driven on `div_out` in the alternate-source path of R4.
- R3: A request is rejected if D exceeds MAX_DIV or if both `old_rate` and `new_rate` are 0. In that case `err` is 1 for exactly the one cycle after acceptance, `div_out` and `sel_alt` do not change, and `busy` and `done` stay 0.
- R4: A request to the alternate source (`req_to_alt`=1) with D>1 sets `div_out` to D in the cycle after acceptance. It sets `sel_alt` to 1 one cycle later.
- R5: A request to the alternate source with D=1 and `old_rate` > 2×`alt_rate` runs a ramp. The outputs become `div_out`=2, then `div_out`=3, then `sel_alt`=1, then `div_out`=2, then `div_out`=1. The first step is in the cycle after acceptance, and consecutive steps are SETTLE = 10×CLK_MHZ cycles apart.
- R6: A request to the alternate source with D=1 and `old_rate` ≤ 2×`alt_rate` changes only `sel_alt`, to 1, in the cycle after acceptance.
- R7: A request to the main source (`req_to_alt`=0) with D=1 and `new_rate` > 2×`alt_rate` runs the ramp of R5 with the same spacing, except that its middle step sets `sel_alt` to 0.
- R8: A request to the main source with D>1 sets `sel_alt` to 0 in the cycle after acceptance. It sets `div_out` to 1 one cycle later.
- R9: A request to the main source with D=1 and `new_rate` ≤ 2×`alt_rate` changes only `sel_alt`, to 0, in the cycle after acceptance.
- R10: `busy` is 1 from the cycle after acceptance until the final step takes effect. In the cycle where the final values first appear, `done` is 1 for exactly one cycle and `busy` is 0. A `req_valid` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_to_alt | input | 1 | 1 = move to alternate source, 0 = return to main |
| old_rate | input | RATE_W | Current core rate code |
| new_rate | input | RATE_W | Target core rate code |
| alt_rate | input | RATE_W | Alternate PLL rate code |
| div_out | output | DIV_W | Post-divider value |
| sel_alt | output | 1 | Source select, 1 = alternate |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a long ramp. A correct block must leave that request with no effect, while a faulty one would corrupt the step order. To reach it, the stimulus tracks how long each expected sequence should run and raises a conflicting request three cycles into every ramp. Ramps themselves need D=1 together with a rate more than twice the alternate rate. The random mix therefore often draws small alternate rates, and directed cases sit on both sides of the 2× threshold and both sides of MAX_DIV.

// File: rtl/clk_src_ramp_seq.sv
module clk_src_ramp_seq #(
  parameter int RATE_W  = 16,
  parameter int DIV_W   = 4,
  parameter int MAX_DIV = 12,
  parameter int CLK_MHZ = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_to_alt,
  input  logic [RATE_W-1:0] old_rate,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] alt_rate,
  output logic [DIV_W-1:0]  div_out,
  output logic              sel_alt,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int SETTLE = 10 * CLK_MHZ;
  localparam int CNT_W  = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {M_DIV_SEL, M_SEL, M_SEL_DIV, M_RAMP} mode_t;

  logic [RATE_W-1:0] top_rate;
  logic [RATE_W:0]   quot, div_need, ramp_ref, alt_x2;
  logic              bad, wide_gap;
  mode_t             next_mode;

  assign top_rate = (old_rate > new_rate) ? old_rate : new_rate;
  assign quot     = (top_rate == '0) ? '0 :
                    ({1'b0, alt_rate} + {1'b0, top_rate} - 1'b1) / {1'b0, top_rate};
  assign div_need = (quot == '0) ? (RATE_W+1)'(1) : quot;
  assign bad      = (top_rate == '0) || (div_need > (RATE_W+1)'(MAX_DIV));
  assign ramp_ref = {1'b0, (req_to_alt ? old_rate : new_rate)};
  assign alt_x2   = {alt_rate, 1'b0};
  assign wide_gap = ramp_ref > alt_x2;

  always_comb begin
    if (div_need == (RATE_W+1)'(1))
      next_mode = wide_gap ? M_RAMP : M_SEL;
    else
      next_mode = req_to_alt ? M_DIV_SEL : M_SEL_DIV;
  end

  mode_t             mode;
  logic [2:0]        idx;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  d_hold;
  logic              tgt_sel;

  logic              op_sel, op_last;
  logic [DIV_W-1:0]  op_div;

  always_comb begin
    op_sel  = 1'b0;
    op_div  = DIV_W'(1);
    op_last = 1'b0;
    case (mode)
      M_DIV_SEL: begin
        op_sel  = (idx != 3'd0);
        op_div  = d_hold;
        op_last = (idx != 3'd0);
      end
      M_SEL: begin
        op_sel  = 1'b1;
        op_last = 1'b1;
      end
      M_SEL_DIV: begin
        op_sel  = (idx == 3'd0);
        op_last = (idx != 3'd0);
      end
      default: begin
        case (idx)
          3'd0:    op_div = DIV_W'(2);
          3'd1:    op_div = DIV_W'(3);
          3'd2:    op_sel = 1'b1;
          3'd3:    op_div = DIV_W'(2);
          default: begin
            op_div  = DIV_W'(1);
            op_last = 1'b1;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_out <= DIV_W'(1);
      sel_alt <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      mode    <= M_SEL;
      idx     <= '0;
      cnt     <= '0;
      d_hold  <= DIV_W'(1);
      tgt_sel <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (bad) begin
            err <= 1'b1;
          end else begin
            busy    <= 1'b1;
            mode    <= next_mode;
            idx     <= '0;
            cnt     <= '0;
            d_hold  <= div_need[DIV_W-1:0];
            tgt_sel <= req_to_alt;
          end
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        if (op_sel) sel_alt <= tgt_sel;
        else        div_out <= op_div;
        if (op_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 3'd1;
          cnt <= (mode == M_RAMP) ? CNT_W'(SETTLE - 1) : '0;
        end
      end
    end
  end
endmodule

module clk_src_ramp_seq_chk #(
  parameter int DIV_W   = 4,
  parameter int MAX_DIV = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_out,
  input logic             sel_alt,
  input logic             busy,
  input logic             done,
  input logic             err
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done && $stable(div_out) && $stable(sel_alt)));
  p_change_in_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_out) || !$stable(sel_alt)) |-> (busy || done));
  p_one_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_alt) |-> $stable(div_out));
  p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out >= DIV_W'(1)) && (div_out <= DIV_W'(MAX_DIV)));
endmodule

bind clk_src_ramp_seq clk_src_ramp_seq_chk #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) i_chk (
  .clk(clk), .rst_n(rst_n), .div_out(div_out), .sel_alt(sel_alt),
  .busy(busy), .done(done), .err(err));

// File: tb/test_clk_src_ramp_seq.sv
module test_clk_src_ramp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W = 16;
  localparam int DIV_W = 4;
  localparam int MAX_DIV = 12;
  localparam int CLK_MHZ = 2;
  localparam int S = 10 * CLK_MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_to_alt = 1'b0;
  logic [RATE_W-1:0] old_rate = '0, new_rate = '0, alt_rate = '0;
  logic [DIV_W-1:0] div_out;
  logic sel_alt, busy, done, err;

  clk_src_ramp_seq #(.RATE_W(RATE_W), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .CLK_MHZ(CLK_MHZ))
    i_clk_src_ramp_seq (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_to_alt(req_to_alt),
      .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
      .div_out(div_out), .sel_alt(sel_alt), .busy(busy), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int mdl_div = 1;
  bit mdl_sel = 0;
  int e_off[8], e_div[8];
  bit e_sel[8];
  int e_n, e_last;
  bit e_err;
  string e_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int off, bit is_sel, int val);
    bit chg;
    chg = is_sel ? (mdl_sel != val[0]) : (mdl_div != val);
    if (is_sel) mdl_sel = val[0]; else mdl_div = val;
    if (chg && e_n < 8) begin
      e_off[e_n] = off; e_div[e_n] = mdl_div; e_sel[e_n] = mdl_sel; e_n++;
    end
    e_last = off;
  endtask

  task automatic plan(bit to_alt, int o, int n, int a);
    int top, d, rref;
    e_n = 0; e_err = 0; e_last = 0;
    top = (o > n) ? o : n;
    if (top == 0) begin e_err = 1; e_tag = "R3"; return; end
    d = (a + top - 1) / top;
    if (d == 0) d = 1;
    if (d > MAX_DIV) begin e_err = 1; e_tag = "R3"; return; end
    rref = to_alt ? o : n;
    if (d == 1 && rref > 2 * a) begin
      e_tag = to_alt ? "R5" : "R7";
      push(1, 0, 2); push(1 + S, 0, 3); push(1 + 2*S, 1, int'(to_alt));
      push(1 + 3*S, 0, 2); push(1 + 4*S, 0, 1);
    end else if (to_alt) begin
      if (d > 1) begin e_tag = "R4"; push(1, 0, d); push(2, 1, 1); end
      else begin e_tag = "R6"; push(1, 1, 1); end
    end else begin
      if (d > 1) begin e_tag = "R8"; push(1, 1, 0); push(2, 0, 1); end
      else begin e_tag = "R9"; push(1, 1, 0); end
    end
  endtask

  task automatic run(bit to_alt, int o, int n, int a, bit inject);
    int o_off[8], o_div[8];
    bit o_sel[8];
    int o_n, done_at, pd;
    bit ps, busy_bad, err_seen;
    plan(to_alt, o, n, a);
    @(negedge clk);
    pd = int'(div_out); ps = sel_alt;
    req_valid = 1; req_to_alt = to_alt;
    old_rate = RATE_W'(o); new_rate = RATE_W'(n); alt_rate = RATE_W'(a);
    o_n = 0; done_at = -1; busy_bad = 0; err_seen = 0;
    for (int k = 0; k < 8 * S; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 0;
      if (int'(div_out) != pd || sel_alt != ps) begin
        if (o_n < 8) begin o_off[o_n] = k; o_div[o_n] = int'(div_out); o_sel[o_n] = sel_alt; end
        o_n++;
        pd = int'(div_out); ps = sel_alt;
      end
      if (e_err) begin
        if (k == 0) err_seen = err;
        if (busy || done) busy_bad = 1;
        if (k == 2) break;
      end else begin
        if (inject && e_last >= 5) begin
          if (k == 3) begin
            req_valid = 1; req_to_alt = !to_alt;
            old_rate = RATE_W'($urandom % 3000); new_rate = RATE_W'($urandom % 3000);
            alt_rate = RATE_W'($urandom % 200);
          end
          if (k == 4) req_valid = 0;
        end
        if (done) begin
          done_at = k;
          if (busy) busy_bad = 1;
          break;
        end
        if (!busy) busy_bad = 1;
      end
    end
    if (e_err) begin
      chk(err_seen, "R3", "err pulse", int'(err_seen), 1);
      chk(o_n == 0, "R3", "output changes on reject", o_n, 0);
      chk(!busy_bad, "R3", "busy/done on reject", int'(busy_bad), 0);
    end else begin
      chk(done_at == e_last, "R10", "done cycle", done_at, e_last);
      chk(!busy_bad, "R10", "busy window", int'(busy_bad), 0);
      chk(o_n == e_n, e_tag, "change count", o_n, e_n);
      for (int i = 0; i < e_n && i < o_n; i++) begin
        chk(o_off[i] == e_off[i], e_tag, "step cycle", o_off[i], e_off[i]);
        chk(o_div[i] == e_div[i], e_tag, "step divider", o_div[i], e_div[i]);
        chk(o_sel[i] == e_sel[i], e_tag, "step select", int'(o_sel[i]), int'(e_sel[i]));
      end
    end
    chk(int'(div_out) == mdl_div, "R2", "final divider", int'(div_out), mdl_div);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(div_out == 1, "R1", "reset divider", int'(div_out), 1);
    chk(sel_alt == 0, "R1", "reset select", int'(sel_alt), 0);
    chk(!busy && !done && !err, "R1", "reset flags", int'({busy, done, err}), 0);
    rst_n = 1;
    @(negedge clk);
    run(1, 1000, 900, 400, 1);   // R5 ramp
    run(0, 400, 1000, 400, 1);   // R7 ramp
    run(1, 600, 500, 300, 0);    // R6 at 2x boundary
    run(0, 300, 601, 300, 0);    // R7 just past boundary
    run(1, 100, 100, 1200, 0);   // R4 with D = MAX_DIV
    run(0, 100, 100, 350, 0);    // R8
    run(1, 100, 100, 1201, 0);   // R3 D = MAX_DIV+1
    run(1, 0, 0, 5, 0);          // R3 zero rates
    run(1, 500, 500, 0, 0);      // R2 zero quotient treated as 1
    run(0, 500, 200, 300, 0);    // R9
    for (int t = 0; t < 250; t++) begin
      int o, n, a;
      o = $urandom % 3000; n = $urandom % 3000;
      a = ($urandom % 3 == 0) ? ($urandom % 1500) : ($urandom % 4000);
      run(1'($urandom % 2), o, n, a, 1'($urandom % 2));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule